// File: doc/BRIEF.md
# ADC Channel Window Readout with Zero Suppression

This block serves a single ADC channel. Every incoming sample is compared with a baseline that the block learns on its own, as an exponential moving average. A sample whose distance from that baseline passes a programmed signed threshold counts as "over". The first over sample of a pulse raises a one-cycle trigger request toward the trigger system. Samples are summed in groups of a programmable size (downsampling) and written into a circular buffer whose depth is chosen at run time, up to a maximum fixed at build time.

When a readout trigger comes in, the block goes on storing a programmed number of further values. It then looks at the last N stored values, the window. It first scans the window for any over sample. If it finds one, it emits the window oldest first as a word stream with valid and last flags. If it finds none, the window is dropped and no words appear. The same threshold drives both the trigger request and this suppression. Readout triggers that arrive while a window is being handled are ignored.

Top module: `adc_window_readout`

## Requirements
- R1: The first valid sample after reset seeds the baseline accumulator with sample·2^BASE_SHIFT. Each later valid sample that is not over updates it to acc − (acc >> BASE_SHIFT) + sample. An over sample leaves it unchanged. The baseline is acc >> BASE_SHIFT.
- R2: A valid sample (other than the seeding one) is over when, with dev = sample − baseline as a signed value, dev > cfgThreshold for a threshold ≥ 0, or dev < cfgThreshold for a negative threshold. A dev equal to the threshold is not over.
- R3: trigReq is high for exactly one cycle, in the cycle after a valid over sample, provided the previous valid sample was not over.
- R4: With cfgDownsample = N (1..DS_MAX), every N consecutive valid samples are summed into one stored value. A stored value is marked as hit if any sample in its group was over.
- R5: Stored values go into a circular buffer of cfgDepth entries (cfgDepth is set while reset is held). The window is the last cfgReadLen stored values (1 ≤ cfgReadLen ≤ cfgDepth) and is emitted oldest first, including when it wraps past the buffer end.
- R6: After a readout trigger is accepted, exactly cfgPostLen more values are stored before the window is taken. A value of 0 takes the window at once.
- R7: A window that holds no hit value produces no output words.
- R8: An emitted window appears as cfgReadLen words on consecutive cycles with outValid high. outLast is high only with the final word.
- R9: readTrig is ignored, and the buffer is not written, from the point where the window is taken until its last word or its drop.
- R10: During and right after reset, trigReq, outValid and outLast are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Sample strobe |
| sampleIn | input | SAMPLE_W | Unsigned ADC sample |
| cfgDepth | input | AW+1 | Buffer entries in use |
| cfgReadLen | input | AW+1 | Words per window |
| cfgPostLen | input | AW+1 | Values stored after the readout trigger |
| cfgDownsample | input | DSW | Samples summed per stored value |
| cfgThreshold | input | SAMPLE_W+1 | Signed offset from baseline |
| readTrig | input | 1 | Readout trigger |
| trigReq | output | 1 | One-cycle threshold crossing request |
| outValid | output | 1 | Output word valid |
| outLast | output | 1 | Final word of a window |
| outData | output | STORE_W | Stored (summed) sample value |

## Verification
The bench builds the block with a 16-entry maximum buffer, a downsampling limit of 4 and a baseline shift of 2. The small shift keeps the moving average simple enough to work out by hand, so the exact sample where a threshold crossing begins and ends can be predicted. A run-time depth of 4 makes the window wrap past the buffer end within a handful of samples. A summing factor of 2 is enough to show that a hit mark travels with a summed value, and the windows cover both threshold polarities.

// File: rtl/adcro_pkg.sv
package adcro_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POST,
    ST_LOAD,
    ST_SCAN,
    ST_SEND
  } roState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic storeEn;  // buffer may be written
    logic loadRd;   // set read pointer to window start
    logic advRd;    // step read pointer
    logic clrHit;   // clear window hit accumulator
    logic accHit;   // fold current entry's hit mark in
    logic emit;     // present current entry as output word
    logic last;     // this word closes the window
  } ctrlStrobe_t;

endpackage

// File: rtl/adcro_datapath.sv
module adcro_datapath
  import adcro_pkg::*;
#(
  parameter int SAMPLE_W   = 12,
  parameter int MAX_DEPTH  = 256,
  parameter int DS_MAX     = 16,
  parameter int BASE_SHIFT = 4,
  localparam int AW      = $clog2(MAX_DEPTH),
  localparam int DSW     = $clog2(DS_MAX + 1),
  localparam int STORE_W = SAMPLE_W + $clog2(DS_MAX)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sampleValid,
  input  logic [SAMPLE_W-1:0]       sampleIn,
  input  logic [AW:0]               cfgDepth,
  input  logic [AW:0]               cfgReadLen,
  input  logic [DSW-1:0]            cfgDownsample,
  input  logic signed [SAMPLE_W:0]  cfgThreshold,
  input  ctrlStrobe_t               strobe,
  output logic                      groupDone,
  output logic                      hitNow,
  output logic                      trigReq,
  output logic                      outValid,
  output logic                      outLast,
  output logic [STORE_W-1:0]        outData
);

  localparam int ACC_W = SAMPLE_W + BASE_SHIFT;

  // ---------------- baseline and threshold ----------------
  logic [ACC_W-1:0]             baseAcc;
  logic                         seeded;
  logic                         overPrev;
  logic [SAMPLE_W-1:0]          baseline;
  logic signed [SAMPLE_W+1:0]   deviation;
  logic signed [SAMPLE_W+1:0]   thrExt;
  logic                         isOver;

  assign baseline  = baseAcc[ACC_W-1 -: SAMPLE_W];
  assign deviation = $signed({2'b00, sampleIn}) - $signed({2'b00, baseline});
  assign thrExt    = {cfgThreshold[SAMPLE_W], cfgThreshold};
  assign isOver    = seeded && (cfgThreshold[SAMPLE_W] ? (deviation < thrExt)
                                                       : (deviation > thrExt));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAcc  <= '0;
      seeded   <= 1'b0;
      overPrev <= 1'b0;
      trigReq  <= 1'b0;
    end else begin
      trigReq <= sampleValid && isOver && !overPrev;
      if (sampleValid) begin
        overPrev <= isOver;
        if (!seeded) begin
          baseAcc <= ACC_W'(sampleIn) << BASE_SHIFT;
          seeded  <= 1'b1;
        end else if (!isOver) begin
          baseAcc <= baseAcc - (baseAcc >> BASE_SHIFT) + ACC_W'(sampleIn);
        end
      end
    end
  end

  // ---------------- downsampling ----------------
  logic [DSW-1:0]     dsCnt;
  logic [STORE_W-1:0] dsSum;
  logic               dsHit;
  logic               dsLast;
  logic [STORE_W-1:0] groupSum;
  logic               groupHit;

  assign dsLast    = ({1'b0, dsCnt} + 1'b1) >= {1'b0, cfgDownsample};
  assign groupSum  = dsSum + STORE_W'(sampleIn);
  assign groupHit  = dsHit | isOver;
  assign groupDone = sampleValid && dsLast && strobe.storeEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dsCnt <= '0;
      dsSum <= '0;
      dsHit <= 1'b0;
    end else if (sampleValid) begin
      if (dsLast) begin
        dsCnt <= '0;
        dsSum <= '0;
        dsHit <= 1'b0;
      end else begin
        dsCnt <= dsCnt + 1'b1;
        dsSum <= groupSum;
        dsHit <= groupHit;
      end
    end
  end

  // ---------------- circular buffer ----------------
  logic [STORE_W:0] mem [MAX_DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr, wrNext, rdNext, startPtr;
  logic [AW:0]      startWide;
  logic [STORE_W:0] rdWord;
  logic             hitAcc;

  assign wrNext    = (({1'b0, wrPtr} + 1'b1) == cfgDepth) ? '0 : wrPtr + 1'b1;
  assign rdNext    = (({1'b0, rdPtr} + 1'b1) == cfgDepth) ? '0 : rdPtr + 1'b1;
  assign startWide = ({1'b0, wrPtr} >= cfgReadLen) ? {1'b0, wrPtr} - cfgReadLen
                                                   : {1'b0, wrPtr} + cfgDepth - cfgReadLen;
  assign startPtr  = startWide[AW-1:0];
  assign rdWord    = mem[rdPtr];
  assign hitNow    = hitAcc | rdWord[STORE_W];

  always_ff @(posedge clk) begin
    if (groupDone) mem[wrPtr] <= {groupHit, groupSum};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      hitAcc   <= 1'b0;
      outValid <= 1'b0;
      outLast  <= 1'b0;
      outData  <= '0;
    end else begin
      if (groupDone) wrPtr <= wrNext;
      if (strobe.loadRd)     rdPtr <= startPtr;
      else if (strobe.advRd) rdPtr <= rdNext;
      if (strobe.clrHit)      hitAcc <= 1'b0;
      else if (strobe.accHit) hitAcc <= hitNow;
      outValid <= strobe.emit;
      outLast  <= strobe.emit && strobe.last;
      outData  <= strobe.emit ? rdWord[STORE_W-1:0] : '0;
    end
  end

  // ---------------- assertions ----------------
  assert_trig_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    trigReq |=> !trigReq);

  // R1: an over sample never moves the baseline
  assert_base_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && isOver) |=> $stable(baseAcc));

  assert_ptr_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDepth != '0) |-> ({1'b0, wrPtr} < cfgDepth));

  // R7: words only leave for a window whose scan found a hit
  assert_emit_hit_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emit |-> hitAcc);

  assert_burst_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outLast) |=> outValid);

  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.accHit || strobe.emit) |=> $stable(wrPtr));

endmodule

// File: rtl/adcro_ctrl.sv
module adcro_ctrl
  import adcro_pkg::*;
#(
  parameter int MAX_DEPTH = 256,
  localparam int AW = $clog2(MAX_DEPTH)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        readTrig,
  input  logic [AW:0] cfgReadLen,
  input  logic [AW:0] cfgPostLen,
  input  logic        groupDone,
  input  logic        hitNow,
  output ctrlStrobe_t strobe
);

  roState_t    state, stateNxt;
  logic [AW:0] postCnt, postCntNxt;
  logic [AW:0] cnt, cntNxt;
  logic        cntEnd;

  assign cntEnd = (cnt + 1'b1) == cfgReadLen;

  always_comb begin
    stateNxt   = state;
    postCntNxt = postCnt;
    cntNxt     = cnt;
    strobe     = '0;
    unique case (state)
      ST_IDLE: begin
        strobe.storeEn = 1'b1;
        if (readTrig) begin
          postCntNxt = '0;
          stateNxt   = (cfgPostLen == '0) ? ST_LOAD : ST_POST;
        end
      end
      ST_POST: begin
        strobe.storeEn = 1'b1;
        if (groupDone) begin
          if ((postCnt + 1'b1) == cfgPostLen) stateNxt = ST_LOAD;
          else postCntNxt = postCnt + 1'b1;
        end
      end
      ST_LOAD: begin
        strobe.loadRd = 1'b1;
        strobe.clrHit = 1'b1;
        cntNxt        = '0;
        stateNxt      = ST_SCAN;
      end
      ST_SCAN: begin
        strobe.accHit = 1'b1;
        strobe.advRd  = 1'b1;
        if (cntEnd) begin
          cntNxt = '0;
          if (hitNow) begin
            strobe.loadRd = 1'b1;
            stateNxt      = ST_SEND;
          end else begin
            stateNxt = ST_IDLE;
          end
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      ST_SEND: begin
        strobe.emit  = 1'b1;
        strobe.advRd = 1'b1;
        strobe.last  = cntEnd;
        if (cntEnd) stateNxt = ST_IDLE;
        else cntNxt = cnt + 1'b1;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      postCnt <= '0;
      cnt     <= '0;
    end else begin
      state   <= stateNxt;
      postCnt <= postCntNxt;
      cnt     <= cntNxt;
    end
  end

  assert_post_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_POST) |-> (postCnt < cfgPostLen));

  // R9: once sending, only finishing the window leaves the send state
  assert_send_exit_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEND) |=> (state == ST_SEND || state == ST_IDLE));

  assert_scan_exit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN) |=> (state inside {ST_SCAN, ST_SEND, ST_IDLE}));

endmodule

// File: rtl/adc_window_readout.sv
module adc_window_readout
  import adcro_pkg::*;
#(
  parameter int SAMPLE_W   = 12,
  parameter int MAX_DEPTH  = 256,
  parameter int DS_MAX     = 16,
  parameter int BASE_SHIFT = 4,
  localparam int AW      = $clog2(MAX_DEPTH),
  localparam int DSW     = $clog2(DS_MAX + 1),
  localparam int STORE_W = SAMPLE_W + $clog2(DS_MAX)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleValid,
  input  logic [SAMPLE_W-1:0]      sampleIn,
  input  logic [AW:0]              cfgDepth,
  input  logic [AW:0]              cfgReadLen,
  input  logic [AW:0]              cfgPostLen,
  input  logic [DSW-1:0]           cfgDownsample,
  input  logic signed [SAMPLE_W:0] cfgThreshold,
  input  logic                     readTrig,
  output logic                     trigReq,
  output logic                     outValid,
  output logic                     outLast,
  output logic [STORE_W-1:0]       outData
);

  ctrlStrobe_t strobe;
  logic        groupDone;
  logic        hitNow;

  adcro_ctrl #(.MAX_DEPTH(MAX_DEPTH)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .readTrig   (readTrig),
    .cfgReadLen (cfgReadLen),
    .cfgPostLen (cfgPostLen),
    .groupDone  (groupDone),
    .hitNow     (hitNow),
    .strobe     (strobe)
  );

  adcro_datapath #(
    .SAMPLE_W   (SAMPLE_W),
    .MAX_DEPTH  (MAX_DEPTH),
    .DS_MAX     (DS_MAX),
    .BASE_SHIFT (BASE_SHIFT)
  ) uData (
    .clk           (clk),
    .rstN          (rstN),
    .sampleValid   (sampleValid),
    .sampleIn      (sampleIn),
    .cfgDepth      (cfgDepth),
    .cfgReadLen    (cfgReadLen),
    .cfgDownsample (cfgDownsample),
    .cfgThreshold  (cfgThreshold),
    .strobe        (strobe),
    .groupDone     (groupDone),
    .hitNow        (hitNow),
    .trigReq       (trigReq),
    .outValid      (outValid),
    .outLast       (outLast),
    .outData       (outData)
  );

endmodule

// File: tb/sim_adc_window_readout.sv
module sim_adc_window_readout;

  localparam int SAMPLE_W = 12;
  localparam int MAX_DEPTH = 16;
  localparam int DS_MAX = 4;
  localparam int BASE_SHIFT = 2;
  localparam int AW = $clog2(MAX_DEPTH);
  localparam int DSW = $clog2(DS_MAX + 1);
  localparam int STORE_W = SAMPLE_W + $clog2(DS_MAX);

  // {expected trigReq, sample}; threshold +20, shift 2, factor 1
  localparam logic [12:0] TRIG_VEC [12] = '{
    {1'b0, 12'd100}, {1'b0, 12'd101}, {1'b1, 12'd130}, {1'b0, 12'd140},
    {1'b0, 12'd110}, {1'b1, 12'd125}, {1'b0, 12'd100}, {1'b0, 12'd80},
    {1'b1, 12'd117}, {1'b0, 12'd116}, {1'b1, 12'd122}, {1'b0, 12'd101}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [SAMPLE_W-1:0] sampleIn = '0;
  logic [AW:0] cfgDepth = 5'd16;
  logic [AW:0] cfgReadLen = 5'd4;
  logic [AW:0] cfgPostLen = 5'd2;
  logic [DSW-1:0] cfgDownsample = 3'd1;
  logic signed [SAMPLE_W:0] cfgThreshold = 13'sd20;
  logic readTrig = 1'b0;
  logic trigReq, outValid, outLast;
  logic [STORE_W-1:0] outData;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [STORE_W-1:0] wordData [64];
  bit wordLast [64];
  int wordCnt = 0;

  always #2 clk = ~clk;

  adc_window_readout #(
    .SAMPLE_W(SAMPLE_W), .MAX_DEPTH(MAX_DEPTH), .DS_MAX(DS_MAX), .BASE_SHIFT(BASE_SHIFT)
  ) u0 (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .cfgDepth(cfgDepth), .cfgReadLen(cfgReadLen), .cfgPostLen(cfgPostLen),
    .cfgDownsample(cfgDownsample), .cfgThreshold(cfgThreshold), .readTrig(readTrig),
    .trigReq(trigReq), .outValid(outValid), .outLast(outLast), .outData(outData)
  );

  always @(negedge clk) begin
    if (rstN && outValid && wordCnt < 64) begin
      wordData[wordCnt] = outData;
      wordLast[wordCnt] = outLast;
      wordCnt = wordCnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic driveSample(input logic [SAMPLE_W-1:0] v, output bit trig);
    @(negedge clk);
    sampleValid = 1'b1;
    sampleIn = v;
    @(negedge clk);
    sampleValid = 1'b0;
    trig = trigReq;
  endtask

  task automatic pulseTrig();
    @(negedge clk);
    readTrig = 1'b1;
    @(negedge clk);
    readTrig = 1'b0;
  endtask

  task automatic checkWord(input int idx, input int expData, input bit expLast, input string tag);
    check(wordData[idx] == STORE_W'(expData), {tag, " data"}, int'(wordData[idx]), expData);
    check(wordLast[idx] == expLast, "R8 last flag", int'(wordLast[idx]), int'(expLast));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit t;
    int base;
    repeat (4) @(negedge clk);
    check(!trigReq && !outValid && !outLast, "R10 in reset", int'({trigReq, outValid, outLast}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!trigReq && !outValid && !outLast, "R10 after reset", int'({trigReq, outValid, outLast}), 0);

    // R1 baseline seeding/EMA and R2 positive threshold seen through R3 pulses
    for (int i = 0; i < 12; i++) begin
      driveSample(TRIG_VEC[i][11:0], t);
      check(t == TRIG_VEC[i][12], $sformatf("R3 vector %0d", i), int'(t), int'(TRIG_VEC[i][12]));
    end

    // Window A: readLen 4, post 2 -> last four stored values, hit from 122
    base = wordCnt;
    pulseTrig();
    driveSample(12'd101, t);
    check(!t, "R3 quiet post sample", int'(t), 0);
    driveSample(12'd102, t);
    check(!t, "R3 quiet post sample", int'(t), 0);
    pulseTrig();  // arrives while scanning: must be ignored (R9)
    repeat (30) @(negedge clk);
    check(wordCnt - base == 4, "R6 window A word count", wordCnt - base, 4);
    checkWord(base + 0, 122, 1'b0, "R5 A0");
    checkWord(base + 1, 101, 1'b0, "R5 A1");
    checkWord(base + 2, 101, 1'b0, "R6 A2");
    checkWord(base + 3, 102, 1'b1, "R6 A3");

    // a stray trigger would have produced a window holding this hit
    driveSample(12'd102, t);
    driveSample(12'd130, t);
    check(t, "R2 crossing at 130", int'(t), 1);
    repeat (30) @(negedge clk);
    check(wordCnt - base == 4, "R9 ignored trigger", wordCnt - base, 4);

    // Window B: four quiet values -> suppressed
    base = wordCnt;
    cfgPostLen = 5'd4;
    pulseTrig();
    for (int i = 0; i < 4; i++) driveSample(12'd102, t);
    repeat (30) @(negedge clk);
    check(wordCnt == base, "R7 quiet window dropped", wordCnt - base, 0);

    // Window C: negative threshold, factor 2
    base = wordCnt;
    cfgThreshold = -13'sd20;
    cfgDownsample = 3'd2;
    cfgReadLen = 5'd2;
    cfgPostLen = 5'd2;
    pulseTrig();
    driveSample(12'd102, t);
    driveSample(12'd102, t);
    driveSample(12'd80, t);
    check(t, "R2 negative crossing", int'(t), 1);
    driveSample(12'd102, t);
    check(!t, "R3 back inside", int'(t), 0);
    repeat (30) @(negedge clk);
    check(wordCnt - base == 2, "R4 window C word count", wordCnt - base, 2);
    checkWord(base + 0, 204, 1'b0, "R4 C0");
    checkWord(base + 1, 182, 1'b1, "R4 C1");

    // Window D: run-time depth 4, window wraps, post 0
    @(negedge clk);
    rstN = 1'b0;
    cfgDepth = 5'd4;
    cfgDownsample = 3'd1;
    cfgThreshold = 13'sd20;
    cfgReadLen = 5'd4;
    cfgPostLen = 5'd0;
    repeat (3) @(negedge clk);
    check(!trigReq && !outValid && !outLast, "R10 second reset", int'({trigReq, outValid, outLast}), 0);
    rstN = 1'b1;
    for (int i = 0; i < 4; i++) driveSample(12'd100, t);
    driveSample(12'd150, t);
    check(t, "R3 crossing at 150", int'(t), 1);
    driveSample(12'd100, t);
    driveSample(12'd100, t);
    base = wordCnt;
    pulseTrig();
    repeat (30) @(negedge clk);
    check(wordCnt - base == 4, "R6 immediate window count", wordCnt - base, 4);
    checkWord(base + 0, 100, 1'b0, "R5 D0");
    checkWord(base + 1, 150, 1'b0, "R5 D1");
    checkWord(base + 2, 100, 1'b0, "R5 D2");
    checkWord(base + 3, 100, 1'b1, "R5 D3");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule